// File: doc/BRIEF.md
# Operand-Snooping Reservation Station

This block holds a small pool of pending operations in front of a single execution unit. A dispatcher hands it one operation at a time over a valid/ready handshake. Each source operand arrives either as a finished value or as the identity of the execution unit that will produce it later. A producer identity of zero means the value is already present.

Every completing unit drives a shared result broadcast made of its unit identity and its result word. Each waiting operand compares its stored identity with the broadcast identity. On a match it takes the data and stops waiting. A slot does not need a separate register name, because it listens for a producer.

Once every operand of a slot is present, the slot may go to the execution unit. When several slots qualify, the one that has waited longest goes first. At most one goes per cycle, and only when the unit accepts it. A slot whose operands never arrive stays occupied. When all slots are held this way, new work cannot enter even if it is independent.

Top module: `rs_station`

## Requirements
- R1: After reset no slot is occupied: `iss_valid` is 0 and `disp_ready` is 1.
- R2: An operation dispatched with both producer tags equal to 0 is offered on the issue port in the next cycle. It carries its opcode and its two values unchanged: source 0 in bits [31:0] and source 1 in bits [63:32] of the value buses.
- R3: A waiting operand whose stored tag equals `bc_tag` while `bc_valid` is 1 takes `bc_data` at that clock edge. Its slot can be offered on the issue port in the following cycle.
- R4: A broadcast with a different tag has no effect on a slot, and so does `bc_valid` being 0. An operand dispatched with tag 0 keeps its dispatched value whatever is broadcast.
- R5: A slot with any operand still waiting is never offered on the issue port.
- R6: Among slots whose operands are all present, the one dispatched earliest is offered.
- R7: At most one slot leaves per cycle, and only in a cycle where `iss_valid` and `iss_ready` are both 1. While `iss_ready` is 0, the offered slot stays offered.
- R8: If a broadcast matches a tag in the same cycle that tag is being dispatched, the new slot takes the broadcast data and does not wait.
- R9: With all four slots occupied, `disp_ready` is 0 unless a slot is leaving in that same cycle. When one is leaving, `disp_ready` is 1 and the new operation reuses the freed slot.
- R10: A slot stuck on a missing operand stays occupied for as long as the operand is missing.
- R11: A single broadcast fills every waiting operand that carries its tag, including both operands of one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatcher offers an operation |
| disp_ready | output | 1 | A slot is free, or one is freeing this cycle |
| disp_op | input | 4 | Opcode of the offered operation |
| disp_tags | input | 8 | Producer tag per source, 4 bits each, 0 means value present |
| disp_vals | input | 64 | Value per source, 32 bits each |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | 4 | Identity of the broadcasting unit |
| bc_data | input | 32 | Broadcast result word |
| iss_valid | output | 1 | A slot with all operands present is offered |
| iss_ready | input | 1 | Execution unit accepts the offered slot |
| iss_op | output | 4 | Opcode of the offered slot |
| iss_vals | output | 64 | Operand values of the offered slot |

## Verification
Independent operations are sent with arithmetically varied values to show that the data path carries both sources intact. Every nonzero producer tag is tried with each operand waiting alone and with both waiting together. Each of these is preceded by a wrong-tag broadcast and an idle bus, which separates a tag comparator that really matches from one that matches too loosely. Mixed ready and waiting slots, a held unit, and a station full of stuck slots that is later released show oldest-first choice, back-pressure, and reuse of a slot in the cycle it leaves.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int RS_SLOTS  = 4;
    localparam int RS_SRCS   = 2;
    localparam int RS_DATA_W = 32;
    localparam int RS_TAG_W  = 4;
    localparam int RS_OP_W   = 4;
    localparam int RS_AGE_W  = (RS_SLOTS > 1) ? $clog2(RS_SLOTS) : 1;
    localparam int RS_IDX_W  = (RS_SLOTS > 1) ? $clog2(RS_SLOTS) : 1;

    typedef logic [RS_TAG_W-1:0]  tag_t;
    typedef logic [RS_DATA_W-1:0] data_t;
    typedef logic [RS_OP_W-1:0]   op_t;
    typedef logic [RS_AGE_W-1:0]  age_t;

    typedef struct packed {
        tag_t  tag;
        data_t val;
    } operand_t;

    // Fill a waiting operand from the result broadcast when the producer matches.
    function automatic operand_t snoop(operand_t cur, logic bv, tag_t bt, data_t bd);
        operand_t r;
        r = cur;
        if (bv && (cur.tag != '0) && (cur.tag == bt)) begin
            r.tag = '0;
            r.val = bd;
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      alloc,
    input  op_t                       alloc_op,
    input  operand_t [RS_SRCS-1:0]    alloc_src,
    input  logic                      grant,
    input  logic                      fire,
    input  age_t                      fire_age,
    input  logic                      accept,
    input  logic                      bc_valid,
    input  tag_t                      bc_tag,
    input  data_t                     bc_data,
    output logic                      busy,
    output logic                      ready,
    output age_t                      age,
    output op_t                       op,
    output operand_t [RS_SRCS-1:0]    src
);
    age_t age_nxt;

    always_comb begin
        ready = busy;
        for (int j = 0; j < RS_SRCS; j++) begin
            if (src[j].tag != '0) ready = 1'b0;
        end
    end

    // Age counts younger occupants: up on every accepted dispatch,
    // down when an entry younger than this one leaves.
    always_comb begin
        age_nxt = age;
        if (accept) age_nxt = age_nxt + age_t'(1);
        if (fire && (age > fire_age)) age_nxt = age_nxt - age_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            age  <= '0;
            op   <= '0;
            src  <= '0;
        end else if (alloc) begin
            busy <= 1'b1;
            age  <= '0;
            op   <= alloc_op;
            for (int j = 0; j < RS_SRCS; j++) begin
                src[j] <= snoop(alloc_src[j], bc_valid, bc_tag, bc_data);
            end
        end else begin
            if (fire && grant) busy <= 1'b0;
            if (busy) begin
                age <= age_nxt;
                for (int j = 0; j < RS_SRCS; j++) begin
                    src[j] <= snoop(src[j], bc_valid, bc_tag, bc_data);
                end
            end
        end
    end
endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick
    import rs_pkg::*;
(
    input  logic [RS_SLOTS-1:0]  ready,
    input  age_t [RS_SLOTS-1:0]  ages,
    output logic [RS_SLOTS-1:0]  grant,
    output logic                 any
);
    logic [RS_IDX_W-1:0] sel;
    age_t                best;

    always_comb begin
        any  = 1'b0;
        sel  = '0;
        best = '0;
        for (int i = 0; i < RS_SLOTS; i++) begin
            if (ready[i] && (!any || (ages[i] > best))) begin
                any  = 1'b1;
                best = ages[i];
                sel  = RS_IDX_W'(i);
            end
        end
        grant = '0;
        for (int i = 0; i < RS_SLOTS; i++) begin
            if (any && (sel == RS_IDX_W'(i))) grant[i] = 1'b1;
        end
    end
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          disp_valid,
    output logic                          disp_ready,
    input  logic [RS_OP_W-1:0]            disp_op,
    input  logic [RS_SRCS*RS_TAG_W-1:0]   disp_tags,
    input  logic [RS_SRCS*RS_DATA_W-1:0]  disp_vals,
    input  logic                          bc_valid,
    input  logic [RS_TAG_W-1:0]           bc_tag,
    input  logic [RS_DATA_W-1:0]          bc_data,
    output logic                          iss_valid,
    input  logic                          iss_ready,
    output logic [RS_OP_W-1:0]            iss_op,
    output logic [RS_SRCS*RS_DATA_W-1:0]  iss_vals
);
    operand_t [RS_SRCS-1:0]               disp_src;
    logic     [RS_SLOTS-1:0]              busy, ready, grant, freeable, alloc_vec;
    age_t     [RS_SLOTS-1:0]              ages;
    op_t      [RS_SLOTS-1:0]              ops;
    operand_t [RS_SLOTS-1:0][RS_SRCS-1:0] srcs;
    logic                                 fire, accept, any_ready;
    age_t                                 fire_age;

    for (genvar j = 0; j < RS_SRCS; j++) begin : g_unpack
        assign disp_src[j].tag = disp_tags[j*RS_TAG_W +: RS_TAG_W];
        assign disp_src[j].val = disp_vals[j*RS_DATA_W +: RS_DATA_W];
    end

    rs_oldest_pick u_pick (
        .ready (ready),
        .ages  (ages),
        .grant (grant),
        .any   (any_ready)
    );

    assign iss_valid  = any_ready;
    assign fire       = iss_valid & iss_ready;
    assign freeable   = ~busy | (grant & {RS_SLOTS{fire}});
    assign disp_ready = |freeable;
    assign accept     = disp_valid & disp_ready;

    // Lowest-numbered free slot takes the new operation.
    always_comb begin
        logic taken;
        taken     = 1'b0;
        alloc_vec = '0;
        for (int i = 0; i < RS_SLOTS; i++) begin
            if (accept && freeable[i] && !taken) begin
                alloc_vec[i] = 1'b1;
                taken        = 1'b1;
            end
        end
    end

    always_comb begin
        fire_age = '0;
        iss_op   = '0;
        iss_vals = '0;
        for (int i = 0; i < RS_SLOTS; i++) begin
            if (grant[i]) begin
                fire_age = fire_age | ages[i];
                iss_op   = iss_op | ops[i];
                for (int j = 0; j < RS_SRCS; j++) begin
                    iss_vals[j*RS_DATA_W +: RS_DATA_W] =
                        iss_vals[j*RS_DATA_W +: RS_DATA_W] | srcs[i][j].val;
                end
            end
        end
    end

    for (genvar i = 0; i < RS_SLOTS; i++) begin : g_slot
        rs_entry u_entry (
            .clk       (clk),
            .rst       (rst),
            .alloc     (alloc_vec[i]),
            .alloc_op  (disp_op),
            .alloc_src (disp_src),
            .grant     (grant[i]),
            .fire      (fire),
            .fire_age  (fire_age),
            .accept    (accept),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_data   (bc_data),
            .busy      (busy[i]),
            .ready     (ready[i]),
            .age       (ages[i]),
            .op        (ops[i]),
            .src       (srcs[i])
        );
    end
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk
    import rs_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [RS_SLOTS-1:0]               busy,
    input  logic [RS_SLOTS-1:0]               ready,
    input  logic [RS_SLOTS-1:0]               grant,
    input  age_t [RS_SLOTS-1:0]               ages,
    input  operand_t [RS_SLOTS-1:0][RS_SRCS-1:0] srcs,
    input  logic                              bc_valid,
    input  logic [RS_TAG_W-1:0]               bc_tag,
    input  logic [RS_DATA_W-1:0]              bc_data,
    input  logic                              iss_valid,
    input  logic                              iss_ready,
    input  logic                              disp_ready
);
    logic fire;
    assign fire = iss_valid & iss_ready;

    assert_single_grant_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_hold_offer_R7: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready) |=> iss_valid);

    assert_full_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        ((&busy) && !fire) |-> !disp_ready);

    for (genvar i = 0; i < RS_SLOTS; i++) begin : g_e
        assert_stuck_stays_R10: assert property (@(posedge clk) disable iff (rst)
            (busy[i] && !(fire && grant[i])) |=> busy[i]);

        for (genvar k = 0; k < RS_SLOTS; k++) begin : g_k
            if (k != i) begin : g_other
                assert_oldest_first_R6: assert property (@(posedge clk) disable iff (rst)
                    (grant[i] && ready[k]) |-> (ages[i] > ages[k]));
            end
        end

        for (genvar j = 0; j < RS_SRCS; j++) begin : g_s
            assert_waiting_not_granted_R5: assert property (@(posedge clk) disable iff (rst)
                (srcs[i][j].tag != '0) |-> !grant[i]);

            assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
                (busy[i] && !(fire && grant[i]) && (srcs[i][j].tag != '0)
                 && bc_valid && (bc_tag == srcs[i][j].tag))
                |=> ((srcs[i][j].tag == '0) && (srcs[i][j].val == $past(bc_data))));

            assert_no_stray_update_R4: assert property (@(posedge clk) disable iff (rst)
                (busy[i] && !(fire && grant[i])
                 && !(bc_valid && (bc_tag == srcs[i][j].tag)))
                |=> $stable(srcs[i][j]));
        end
    end
endmodule

bind rs_station rs_station_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .ready      (ready),
    .grant      (grant),
    .ages       (ages),
    .srcs       (srcs),
    .bc_valid   (bc_valid),
    .bc_tag     (bc_tag),
    .bc_data    (bc_data),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .disp_ready (disp_ready)
);

// File: tb/sim_rs_station.sv
`timescale 1ns/1ps
module sim_rs_station;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        disp_valid = 1'b0;
    logic        disp_ready;
    logic [3:0]  disp_op = '0;
    logic [7:0]  disp_tags = '0;
    logic [63:0] disp_vals = '0;
    logic        bc_valid = 1'b0;
    logic [3:0]  bc_tag = '0;
    logic [31:0] bc_data = '0;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic [3:0]  iss_op;
    logic [63:0] iss_vals;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rs_station u0 (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
        .disp_tags(disp_tags), .disp_vals(disp_vals),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_op(iss_op), .iss_vals(iss_vals)
    );

    function automatic logic [31:0] va(int i);
        return (32'(i) * 32'h9E37_79B9) ^ 32'h0F0F_0000;
    endfunction
    function automatic logic [31:0] vb(int i);
        return (32'(i) * 32'h7F4A_7C15) + 32'h0000_1234;
    endfunction
    function automatic logic [31:0] vd(int t);
        return 32'hC0DE_0000 | 32'(t * 257);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic disp(input logic [3:0] op, input logic [3:0] t0, input logic [31:0] v0,
                        input logic [3:0] t1, input logic [31:0] v1);
        disp_valid = 1'b1;
        disp_op    = op;
        disp_tags  = {t1, t0};
        disp_vals  = {v1, v0};
    endtask

    task automatic check_issue(input string req, input logic [3:0] op,
                               input logic [31:0] v0, input logic [31:0] v1);
        chk(iss_valid == 1'b1, req, 64'(iss_valid), 64'd1);
        chk(iss_op == op, req, 64'(iss_op), 64'(op));
        chk(iss_vals == {v1, v0}, req, iss_vals, {v1, v0});
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: empty after reset
        chk(disp_ready == 1'b1, "R1 ready", 64'(disp_ready), 64'd1);
        chk(iss_valid == 1'b0, "R1 idle", 64'(iss_valid), 64'd0);

        // R2: independent operations, varied values
        iss_ready = 1'b1;
        for (int i = 0; i < 8; i++) begin
            disp(4'(i), 4'd0, va(i), 4'd0, vb(i));
            step();
            disp_valid = 1'b0;
            #1;
            check_issue("R2", 4'(i), va(i), vb(i));
            step();
            #1;
            chk(iss_valid == 1'b0, "R7 single issue", 64'(iss_valid), 64'd0);
        end

        // R3/R4/R5/R11: every tag, each waiting pattern
        for (int t = 1; t < 16; t++) begin
            for (int m = 1; m < 4; m++) begin
                logic [3:0]  t0, t1;
                logic [31:0] e0, e1;
                t0 = m[0] ? 4'(t) : 4'd0;
                t1 = m[1] ? 4'(t) : 4'd0;
                e0 = m[0] ? vd(t) : va(t + m);
                e1 = m[1] ? vd(t) : vb(t + m);
                disp(4'(m), t0, 32'hDEAD_0000 | 32'(t), t1, m[1] ? 32'hBEEF_0000 : vb(t + m));
                if (!m[0]) disp_vals[31:0] = va(t + m);
                step();
                disp_valid = 1'b0;
                #1;
                chk(iss_valid == 1'b0, "R5 waiting", 64'(iss_valid), 64'd0);
                bc_valid = 1'b1;
                bc_tag   = 4'((t % 15) + 1);
                bc_data  = 32'h5555_AAAA;
                step();
                bc_valid = 1'b0;
                bc_tag   = 4'(t);
                #1;
                chk(iss_valid == 1'b0, "R4 wrong tag", 64'(iss_valid), 64'd0);
                step();
                #1;
                chk(iss_valid == 1'b0, "R4 bus idle", 64'(iss_valid), 64'd0);
                bc_valid = 1'b1;
                bc_data  = vd(t);
                step();
                bc_valid = 1'b0;
                #1;
                check_issue(m == 3 ? "R11 both" : "R3 R4 capture", 4'(m), e0, e1);
                step();
            end
        end

        // R5: two different producers
        disp(4'd9, 4'd4, 32'd0, 4'd6, 32'd0);
        step();
        disp_valid = 1'b0;
        bc_valid = 1'b1; bc_tag = 4'd4; bc_data = 32'h0000_0444;
        step();
        bc_tag = 4'd6; bc_data = 32'h0000_0666;
        #1;
        chk(iss_valid == 1'b0, "R5 half ready", 64'(iss_valid), 64'd0);
        step();
        bc_valid = 1'b0;
        #1;
        check_issue("R5 both arrive", 4'd9, 32'h0000_0444, 32'h0000_0666);
        step();

        // R8: broadcast in the dispatch cycle
        disp(4'd11, 4'd0, 32'h1111_2222, 4'd5, 32'hFFFF_FFFF);
        bc_valid = 1'b1; bc_tag = 4'd5; bc_data = 32'hABCD_0005;
        step();
        disp_valid = 1'b0; bc_valid = 1'b0;
        #1;
        check_issue("R8", 4'd11, 32'h1111_2222, 32'hABCD_0005);
        step();

        // R6/R7: ready younger before waiting older, unit held
        iss_ready = 1'b0;
        disp(4'd1, 4'd3, 32'd0, 4'd0, 32'd10); step();
        disp(4'd2, 4'd0, 32'd20, 4'd0, 32'd21); step();
        disp(4'd3, 4'd3, 32'd0, 4'd0, 32'd30); step();
        disp_valid = 1'b0;
        #1;
        check_issue("R6 only ready", 4'd2, 32'd20, 32'd21);
        repeat (3) step();
        #1;
        check_issue("R7 held", 4'd2, 32'd20, 32'd21);
        bc_valid = 1'b1; bc_tag = 4'd3; bc_data = 32'd77;
        step();
        bc_valid = 1'b0;
        #1;
        check_issue("R6 oldest", 4'd1, 32'd77, 32'd10);
        iss_ready = 1'b1;
        step(); #1;
        check_issue("R6 next", 4'd2, 32'd20, 32'd21);
        step(); #1;
        check_issue("R6 last", 4'd3, 32'd77, 32'd30);
        step(); #1;
        chk(iss_valid == 1'b0, "R7 drained", 64'(iss_valid), 64'd0);

        // R9/R10: fill with stuck slots, then release
        for (int k = 0; k < 4; k++) begin
            disp(4'(4 + k), 4'd7, 32'd0, 4'd0, 32'(100 + k));
            step();
        end
        disp(4'd15, 4'd0, 32'h0F0F_0F0F, 4'd0, 32'hF0F0_F0F0);
        #1;
        chk(disp_ready == 1'b0, "R9 full", 64'(disp_ready), 64'd0);
        chk(iss_valid == 1'b0, "R10 stuck", 64'(iss_valid), 64'd0);
        repeat (3) step();
        #1;
        chk(disp_ready == 1'b0, "R10 still held", 64'(disp_ready), 64'd0);
        bc_valid = 1'b1; bc_tag = 4'd7; bc_data = 32'd700;
        step();
        bc_valid = 1'b0;
        #1;
        chk(disp_ready == 1'b1, "R9 reuse", 64'(disp_ready), 64'd1);
        check_issue("R6 full order", 4'd4, 32'd700, 32'd100);
        step();
        disp_valid = 1'b0;
        for (int k = 1; k < 4; k++) begin
            #1;
            check_issue("R6 full order", 4'(4 + k), 32'd700, 32'(100 + k));
            step();
        end
        #1;
        check_issue("R9 reused slot", 4'd15, 32'h0F0F_0F0F, 32'hF0F0_F0F0);
        step(); #1;
        chk(iss_valid == 1'b0, "R9 empty", 64'(iss_valid), 64'd0);
        chk(disp_ready == 1'b1, "R9 empty ready", 64'(disp_ready), 64'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule